// File: doc/BRIEF.md
# Shared-Region Message Queue Controller

This block keeps the pointer state for four word queues that live in one contiguous memory region: inbound free, inbound post, outbound post and outbound free. All four share one base register and one size setting. Each queue owns its own slice of the region. A pointer that steps past the end of its slice returns to the start of that slice.

A local CPU programs the block through a small word-indexed register port. A host-side agent uses two strobes. An inbound write stores a word at the inbound post head and advances that head. An outbound read returns the word at the outbound post tail and advances that tail. The software side moves the other ends of the queues by writing the pointer registers. The block reaches memory through a single request/acknowledge word port and handles one access at a time. While an access is in flight it holds `host_busy` high.

The block also reports a registered empty flag for each queue. When a host post leaves the inbound post queue non-empty, it raises a maskable interrupt.

Top module: `cq_queue_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` and `host_busy` are low, and `q_empty` is 4'b1111.
- R2: The register port uses word index `cpu_addr` with this map: 0 control, 1 base, 2 cause, 3 mask, and 4+2k / 5+2k for the head / tail of queue k. The queue numbers are k=0 inbound free, 1 inbound post, 2 outbound post and 3 outbound free. In the control register, bit 0 is the enable and bits 5:1 are the size field; the other bits read as 0. The base register keeps only bits 31:20 of what is written. `cpu_rdata` is loaded on the clock edge that samples `cpu_re`.
- R3: The queue size S is the size field times 16384 bytes. Queue k occupies the slice that starts at base + k·S and is S bytes long.
- R4: A host inbound write to a non-full queue stores `host_in_data` at the inbound post head address through one memory write. The head then advances by 4.
- R5: A pointer advanced by hardware whose value plus 4 equals the end of its slice is set back to the start of its slice.
- R6: If the next inbound post head would equal the inbound post tail, the host write is dropped. No memory access is made and the head is unchanged.
- R7: A host outbound read of a non-empty outbound post queue reads memory at its tail, returns the word on `host_out_rdata` with a one-cycle `host_out_rvalid`, and advances the tail.
- R8: A host outbound read of an empty outbound post queue (head equals tail) returns 0xFFFFFFFF one cycle later. It makes no memory access and changes no pointer.
- R9: While the enable bit is 0 or the size field is 0, host writes are dropped and host reads return 0xFFFFFFFF, with no memory access.
- R10: `q_empty[k]` equals (head k == tail k), one cycle after the pointers change.
- R11: Cause bit 4 is set when a hardware head update leaves the inbound post queue non-empty. Writing 1 to bit 4 of the cause register clears it; writing 0 there leaves it as it is.
- R12: `irq` is the registered OR of the cause bits ANDed with the inverted mask bits. A mask bit of 1 blocks its cause.
- R13: A memory request keeps its address, direction and data stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register word index |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Registered read data |
| host_in_valid | input | 1 | Host inbound write strobe, honoured when not busy |
| host_in_data | input | 32 | Host inbound word |
| host_out_req | input | 1 | Host outbound read strobe, honoured when not busy |
| host_out_rvalid | output | 1 | Outbound read data valid, one cycle |
| host_out_rdata | output | 32 | Outbound read data |
| host_busy | output | 1 | A memory access is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| q_empty | output | 4 | Per-queue empty flags, bit k is queue k |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest state to reach from the ports is the inbound post queue one slot short of full. Reaching it honestly would take more than four thousand host posts. The stimulus gets there in one step instead: the CPU rewrites the inbound post tail to one word past the head. Slice-end wraparound is reached the same way, by placing both ends of a queue on the last word of its slice before posting or fetching. A seeded random mix of host posts, host fetches, CPU pushes and CPU consumes then runs from pointers parked just below the slice ends. Random acknowledge delays on the memory port run alongside it.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;
  localparam int NQ       = 4;
  localparam int NPTR     = 2 * NQ;
  // register word indices
  localparam int REG_CTRL  = 0;
  localparam int REG_BASE  = 1;
  localparam int REG_CAUSE = 2;
  localparam int REG_MASK  = 3;
  localparam int REG_PTR0  = 4;   // head of queue k at REG_PTR0+2k, tail at +1
  localparam int CAUSE_IP_BIT = 4;
  // queue numbering (also slice order inside the region)
  localparam int Q_IN_FREE  = 0;
  localparam int Q_IN_POST  = 1;
  localparam int Q_OUT_POST = 2;
  localparam int Q_OUT_FREE = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} seq_state_e;
endpackage

// File: rtl/cq_ptr_next.sv
`timescale 1ns/1ps
module cq_ptr_next #(
  parameter int W = 32
) (
  input  logic [W-1:0] ptr,
  input  logic [W-1:0] slice_lo,
  input  logic [W-1:0] slice_len,
  output logic [W-1:0] nxt
);
  localparam int STEP = W / 8;
  logic [W-1:0] inc;
  always_comb begin
    inc = ptr + W'(STEP);
    nxt = (inc == slice_lo + slice_len) ? slice_lo : inc;
  end
endmodule

// File: rtl/cq_regfile.sv
`timescale 1ns/1ps
module cq_regfile
  import cq_pkg::*;
#(
  parameter int W         = 32,
  parameter int UNIT_LG2  = 14,
  parameter int SIZE_W    = 5,
  parameter int BASE_KEEP = 12,
  parameter int RA_W      = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_we,
  input  logic            cpu_re,
  input  logic [RA_W-1:0] cpu_addr,
  input  logic [W-1:0]    cpu_wdata,
  output logic [W-1:0]    cpu_rdata,
  input  logic            adv_ip_head,
  input  logic            adv_op_tail,
  output logic            q_on,
  output logic [W-1:0]    ip_head,
  output logic [W-1:0]    ip_tail,
  output logic [W-1:0]    ip_head_nxt,
  output logic [W-1:0]    op_head,
  output logic [W-1:0]    op_tail,
  output logic [NQ-1:0]   q_empty,
  output logic            irq
);
  localparam int CTRL_W = SIZE_W + 1;
  localparam int IPH = 2 * Q_IN_POST;
  localparam int IPT = 2 * Q_IN_POST + 1;
  localparam int OPH = 2 * Q_OUT_POST;
  localparam int OPT = 2 * Q_OUT_POST + 1;

  logic [CTRL_W-1:0]    ctrl_q;
  logic [BASE_KEEP-1:0] base_q;
  logic                 cause_q;
  logic [W-1:0]         mask_q;
  logic [W-1:0]         ptr_q [NPTR];
  logic [SIZE_W-1:0]    size_f;
  logic [W-1:0]         base_full, qsize, ip_lo, op_lo, op_tail_nxt, cause_vec, rd_mux;
  logic [NQ-1:0]        eq;
  logic                 wr_ctrl, wr_base, wr_cause, wr_mask, cause_set;

  assign size_f    = ctrl_q[CTRL_W-1:1];
  assign q_on      = ctrl_q[0] && (size_f != '0);
  assign base_full = {base_q, {(W-BASE_KEEP){1'b0}}};
  assign qsize     = W'(size_f) << UNIT_LG2;
  assign ip_lo     = base_full + W'(Q_IN_POST) * qsize;
  assign op_lo     = base_full + W'(Q_OUT_POST) * qsize;

  cq_ptr_next #(.W(W)) u_ip_step (
    .ptr(ptr_q[IPH]), .slice_lo(ip_lo), .slice_len(qsize), .nxt(ip_head_nxt));
  cq_ptr_next #(.W(W)) u_op_step (
    .ptr(ptr_q[OPT]), .slice_lo(op_lo), .slice_len(qsize), .nxt(op_tail_nxt));

  assign wr_ctrl  = cpu_we && cpu_addr == RA_W'(REG_CTRL);
  assign wr_base  = cpu_we && cpu_addr == RA_W'(REG_BASE);
  assign wr_cause = cpu_we && cpu_addr == RA_W'(REG_CAUSE);
  assign wr_mask  = cpu_we && cpu_addr == RA_W'(REG_MASK);
  assign cause_set = adv_ip_head && (ip_head_nxt != ptr_q[IPT]);
  assign cause_vec = W'(cause_q) << CAUSE_IP_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      base_q  <= '0;
      cause_q <= 1'b0;
      mask_q  <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= cpu_wdata[CTRL_W-1:0];
      if (wr_base) base_q <= cpu_wdata[W-1 -: BASE_KEEP];
      if (wr_mask) mask_q <= cpu_wdata;
      cause_q <= cause_set || (cause_q && !(wr_cause && cpu_wdata[CAUSE_IP_BIT]));
      irq     <= |(cause_vec & ~mask_q);
    end
  end

  // pointer store: software writes take precedence over hardware steps
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPTR; p++) ptr_q[p] <= '0;
    end else begin
      if (adv_ip_head) ptr_q[IPH] <= ip_head_nxt;
      if (adv_op_tail) ptr_q[OPT] <= op_tail_nxt;
      for (int p = 0; p < NPTR; p++)
        if (cpu_we && cpu_addr == RA_W'(REG_PTR0 + p)) ptr_q[p] <= cpu_wdata;
    end
  end

  generate
    for (genvar k = 0; k < NQ; k++) begin : g_empty
      assign eq[k] = (ptr_q[2*k] == ptr_q[2*k+1]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_empty <= '1;
    else     q_empty <= eq;
  end

  always_comb begin
    rd_mux = '0;
    if (cpu_addr == RA_W'(REG_CTRL))       rd_mux = W'(ctrl_q);
    else if (cpu_addr == RA_W'(REG_BASE))  rd_mux = base_full;
    else if (cpu_addr == RA_W'(REG_CAUSE)) rd_mux = cause_vec;
    else if (cpu_addr == RA_W'(REG_MASK))  rd_mux = mask_q;
    else begin
      for (int p = 0; p < NPTR; p++)
        if (cpu_addr == RA_W'(REG_PTR0 + p)) rd_mux = ptr_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_re) cpu_rdata <= rd_mux;
  end

  assign ip_head = ptr_q[IPH];
  assign ip_tail = ptr_q[IPT];
  assign op_head = ptr_q[OPH];
  assign op_tail = ptr_q[OPT];
endmodule

// File: rtl/cq_port_seq.sv
`timescale 1ns/1ps
module cq_port_seq
  import cq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         q_on,
  input  logic [W-1:0] ip_head,
  input  logic [W-1:0] ip_tail,
  input  logic [W-1:0] ip_head_nxt,
  input  logic [W-1:0] op_head,
  input  logic [W-1:0] op_tail,
  input  logic         host_in_valid,
  input  logic [W-1:0] host_in_data,
  input  logic         host_out_req,
  output logic         host_out_rvalid,
  output logic [W-1:0] host_out_rdata,
  output logic         host_busy,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  output logic         adv_ip_head,
  output logic         adv_op_tail
);
  seq_state_e st_q;
  logic ip_full, op_empty;

  assign ip_full  = (ip_head_nxt == ip_tail);
  assign op_empty = (op_head == op_tail);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q            <= ST_IDLE;
      mem_req         <= 1'b0;
      mem_we          <= 1'b0;
      mem_addr        <= '0;
      mem_wdata       <= '0;
      host_out_rvalid <= 1'b0;
      host_out_rdata  <= '0;
    end else begin
      host_out_rvalid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (host_in_valid) begin
            if (q_on && !ip_full) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= ip_head;
              mem_wdata <= host_in_data;
              st_q      <= ST_WRITE;
            end
          end else if (host_out_req) begin
            if (q_on && !op_empty) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= op_tail;
              st_q     <= ST_READ;
            end else begin
              host_out_rvalid <= 1'b1;
              host_out_rdata  <= '1;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            st_q    <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            mem_req         <= 1'b0;
            host_out_rvalid <= 1'b1;
            host_out_rdata  <= mem_rdata;
            st_q            <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign host_busy   = (st_q != ST_IDLE);
  assign adv_ip_head = (st_q == ST_WRITE) && mem_ack;
  assign adv_op_tail = (st_q == ST_READ) && mem_ack;
endmodule

// File: rtl/cq_queue_ctrl.sv
`timescale 1ns/1ps
module cq_queue_ctrl
  import cq_pkg::*;
#(
  parameter int W         = 32,
  parameter int UNIT_LG2  = 14,
  parameter int SIZE_W    = 5,
  parameter int BASE_KEEP = 12,
  parameter int RA_W      = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_we,
  input  logic            cpu_re,
  input  logic [RA_W-1:0] cpu_addr,
  input  logic [W-1:0]    cpu_wdata,
  output logic [W-1:0]    cpu_rdata,
  input  logic            host_in_valid,
  input  logic [W-1:0]    host_in_data,
  input  logic            host_out_req,
  output logic            host_out_rvalid,
  output logic [W-1:0]    host_out_rdata,
  output logic            host_busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic            mem_ack,
  input  logic [W-1:0]    mem_rdata,
  output logic [NQ-1:0]   q_empty,
  output logic            irq
);
  logic         q_on, adv_ip_head, adv_op_tail;
  logic [W-1:0] ip_head, ip_tail, ip_head_nxt, op_head, op_tail;

  cq_regfile #(
    .W(W), .UNIT_LG2(UNIT_LG2), .SIZE_W(SIZE_W), .BASE_KEEP(BASE_KEEP), .RA_W(RA_W)
  ) u_rf (
    .clk(clk), .rst(rst),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .adv_ip_head(adv_ip_head), .adv_op_tail(adv_op_tail),
    .q_on(q_on), .ip_head(ip_head), .ip_tail(ip_tail), .ip_head_nxt(ip_head_nxt),
    .op_head(op_head), .op_tail(op_tail), .q_empty(q_empty), .irq(irq)
  );

  cq_port_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .q_on(q_on),
    .ip_head(ip_head), .ip_tail(ip_tail), .ip_head_nxt(ip_head_nxt),
    .op_head(op_head), .op_tail(op_tail),
    .host_in_valid(host_in_valid), .host_in_data(host_in_data),
    .host_out_req(host_out_req), .host_out_rvalid(host_out_rvalid),
    .host_out_rdata(host_out_rdata), .host_busy(host_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .adv_ip_head(adv_ip_head), .adv_op_tail(adv_op_tail)
  );
endmodule

// File: rtl/cq_queue_ctrl_chk.sv
`timescale 1ns/1ps
module cq_queue_ctrl_chk
  import cq_pkg::*;
#(
  parameter int W    = 32,
  parameter int RA_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_we,
  input logic [RA_W-1:0] cpu_addr,
  input logic [W-1:0]    cpu_wdata,
  input logic            host_in_valid,
  input logic            host_out_req,
  input logic            host_out_rvalid,
  input logic [W-1:0]    host_out_rdata,
  input logic            host_busy,
  input logic            mem_req,
  input logic            mem_we,
  input logic [W-1:0]    mem_addr,
  input logic [W-1:0]    mem_wdata,
  input logic            mem_ack,
  input logic            q_on,
  input logic            adv_ip_head,
  input logic [W-1:0]    ip_head,
  input logic [W-1:0]    ip_tail,
  input logic [W-1:0]    op_head,
  input logic [W-1:0]    op_tail,
  input logic            irq
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (adv_ip_head && !cpu_we) |=> (ip_head != ip_tail)); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R13

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> host_busy); // R4

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (host_out_req && !host_in_valid && !host_busy && op_head == op_tail)
      |=> (!mem_req && host_out_rvalid && host_out_rdata == '1)); // R8

  AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (!q_on && !host_busy) |=> !mem_req); // R9

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == RA_W'(REG_MASK) && cpu_wdata[CAUSE_IP_BIT])
      ##1 !(cpu_we && cpu_addr == RA_W'(REG_MASK)) |=> !irq); // R12
endmodule

bind cq_queue_ctrl cq_queue_ctrl_chk #(.W(W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .host_in_valid(host_in_valid), .host_out_req(host_out_req),
  .host_out_rvalid(host_out_rvalid), .host_out_rdata(host_out_rdata),
  .host_busy(host_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .q_on(q_on), .adv_ip_head(adv_ip_head),
  .ip_head(ip_head), .ip_tail(ip_tail), .op_head(op_head), .op_tail(op_tail), .irq(irq)
);

// File: tb/test_cq_queue_ctrl.sv
`timescale 1ns/1ps
module test_cq_queue_ctrl;
  localparam logic [31:0] BASE = 32'h1230_0000;
  localparam logic [31:0] S    = 32'h0000_8000;   // size field 2
  localparam logic [31:0] SIP  = BASE + S;
  localparam logic [31:0] SOP  = BASE + 2 * S;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 0, cpu_re = 0;
  logic [3:0]  cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic        host_in_valid = 0, host_out_req = 0;
  logic [31:0] host_in_data = 0;
  logic        host_out_rvalid, host_busy;
  logic [31:0] host_out_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  q_empty;
  logic        irq;

  int n_chk = 0, n_err = 0, mem_txn = 0, hold_bad = 0;
  bit done = 0;
  bit [31:0] mem [bit [31:0]];
  logic [31:0] ifh, ift, iph, ipt, oph, opt, ofh, oft;

  always #4 clk = ~clk;

  cq_queue_ctrl i_cq_queue_ctrl (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .host_in_valid(host_in_valid), .host_in_data(host_in_data),
    .host_out_req(host_out_req), .host_out_rvalid(host_out_rvalid),
    .host_out_rdata(host_out_rdata), .host_busy(host_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .q_empty(q_empty), .irq(irq));

  // memory model with random acknowledge delay
  initial begin
    logic [31:0] req_addr;
    int unsigned wait_cnt;
    bit pend;
    mem_ack = 0; mem_rdata = 0; pend = 0; req_addr = 0; wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; pend = 0;
      end else if (mem_req) begin
        if (!pend) begin pend = 1; req_addr = mem_addr; wait_cnt = $urandom % 3; end
        if (mem_addr !== req_addr) hold_bad++;
        if (wait_cnt == 0) begin
          mem_ack = 1; mem_txn++;
          if (mem_we) mem[mem_addr] = mem_wdata;
          else        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end else wait_cnt--;
      end
    end
  end

  function automatic logic [31:0] step(input logic [31:0] p, input logic [31:0] lo);
    return (p + 32'd4 == lo + S) ? lo : p + 32'd4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic cpu_write(input int a, input logic [31:0] d);
    cpu_we = 1; cpu_addr = 4'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic cpu_read(input int a, output logic [31:0] d);
    cpu_re = 1; cpu_addr = 4'(a);
    @(negedge clk);
    cpu_re = 0;
    d = cpu_rdata;
  endtask

  task automatic host_post(input logic [31:0] d);
    while (host_busy) @(negedge clk);
    host_in_valid = 1; host_in_data = d;
    @(negedge clk);
    host_in_valid = 0;
    while (host_busy) @(negedge clk);
  endtask

  task automatic host_fetch(output logic [31:0] d);
    int guard;
    while (host_busy) @(negedge clk);
    host_out_req = 1;
    @(negedge clk);
    host_out_req = 0;
    guard = 0;
    while (!host_out_rvalid && guard < 50) begin @(negedge clk); guard++; end
    d = host_out_rdata;
    @(negedge clk);
  endtask

  task automatic set_ptrs();
    cpu_write(4, ifh); cpu_write(5, ift); cpu_write(6, iph); cpu_write(7, ipt);
    cpu_write(8, oph); cpu_write(9, opt); cpu_write(10, ofh); cpu_write(11, oft);
  endtask

  function automatic logic [31:0] exp_empty();
    return {28'd0, ofh == oft, oph == opt, iph == ipt, ifh == ift};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    report();
  end

  initial begin
    logic [31:0] r, d;
    int t0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 busy", {31'd0, host_busy}, 32'd0);
    chk("R1 q_empty", {28'd0, q_empty}, 32'hF);
    cpu_read(0, r); chk("R1 ctrl", r, 0);
    cpu_read(2, r); chk("R1 cause", r, 0);
    cpu_read(7, r); chk("R1 pointer", r, 0);

    // R9 disabled: write dropped, read all ones, no memory traffic
    t0 = mem_txn;
    host_post(32'hAAAA_0001);
    host_fetch(r);
    chk("R9 disabled read", r, 32'hFFFF_FFFF);
    chk("R9 disabled no memory access", mem_txn, t0);
    cpu_read(6, r); chk("R9 disabled head unchanged", r, 0);

    // R2 register decode
    cpu_write(1, 32'h1234_5678);
    cpu_read(1, r); chk("R2 base keeps upper bits", r, BASE);
    cpu_write(0, 32'hFFFF_FF85);
    cpu_read(0, r); chk("R2 ctrl field mask", r, 32'h05);

    // R9 enable with size field 0
    cpu_write(0, 32'h1);
    ifh = BASE; ift = BASE; iph = SIP; ipt = SIP; oph = SOP; opt = SOP;
    ofh = BASE + 3 * S; oft = ofh;
    set_ptrs();
    t0 = mem_txn;
    host_post(32'hAAAA_0002);
    chk("R9 size zero no memory access", mem_txn, t0);
    cpu_write(0, 32'h5);

    // R4 / R3 posts into inbound post slice
    for (int i = 0; i < 3; i++) begin
      d = 32'hC0DE_0000 + i;
      t0 = mem_txn;
      host_post(d);
      chk("R4 one memory write", mem_txn, t0 + 1);
      chk("R4 word stored at head", mem.exists(iph) ? mem[iph] : 32'hDEAD_DEAD, d);
      iph = step(iph, SIP);
    end
    cpu_read(6, r); chk("R4 head advanced", r, SIP + 12);
    @(negedge clk);
    chk("R10 inbound post not empty", {28'd0, q_empty}, exp_empty());
    cpu_read(2, r); chk("R11 cause set", r, 32'h10);
    chk("R12 irq raised", {31'd0, irq}, 32'd1);

    // R12 mask, R11 clear
    cpu_write(3, 32'h10);
    @(negedge clk);
    chk("R12 mask blocks irq", {31'd0, irq}, 32'd0);
    cpu_write(2, 32'h0);
    cpu_read(2, r); chk("R11 write 0 keeps cause", r, 32'h10);
    cpu_write(2, 32'h10);
    cpu_read(2, r); chk("R11 write 1 clears cause", r, 32'h0);
    cpu_write(3, 32'h0);
    @(negedge clk);
    chk("R12 unmasked no cause", {31'd0, irq}, 32'd0);

    // R6 full: tail one word past head
    ipt = step(iph, SIP);
    cpu_write(7, ipt);
    t0 = mem_txn;
    host_post(32'hBAD0_0006);
    chk("R6 full drop no access", mem_txn, t0);
    cpu_read(6, r); chk("R6 full head unchanged", r, iph);

    // R5 wrap of inbound post head
    iph = SIP + S - 4; ipt = iph;
    cpu_write(6, iph); cpu_write(7, ipt);
    host_post(32'h5EED_0005);
    chk("R5 word at slice end", mem.exists(SIP + S - 4) ? mem[SIP + S - 4] : 0, 32'h5EED_0005);
    cpu_read(6, r); chk("R5 inbound head wraps", r, SIP);
    iph = SIP;

    // R5 / R7 wrap of outbound post tail
    opt = SOP + S - 4; oph = SOP;
    mem[opt] = 32'h0B0B_0007;
    cpu_write(9, opt); cpu_write(8, oph);
    host_fetch(r);
    chk("R7 outbound word returned", r, 32'h0B0B_0007);
    cpu_read(9, r); chk("R5 outbound tail wraps", r, SOP);
    opt = SOP;
    @(negedge clk);
    chk("R10 outbound post empty again", {28'd0, q_empty}, exp_empty());

    // R8 empty outbound read
    t0 = mem_txn;
    host_fetch(r);
    chk("R8 empty read value", r, 32'hFFFF_FFFF);
    chk("R8 empty read no access", mem_txn, t0);
    cpu_read(9, r); chk("R8 tail unchanged", r, SOP);

    // random phase from pointers parked near slice ends
    iph = SIP + S - 16; ipt = iph; oph = SOP + S - 16; opt = oph;
    cpu_write(6, iph); cpu_write(7, ipt); cpu_write(8, oph); cpu_write(9, opt);
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 4;
      case (op)
        0: begin
          d = $urandom;
          t0 = mem_txn;
          host_post(d);
          if (step(iph, SIP) == ipt) chk("R6 random full drop", mem_txn, t0);
          else begin
            chk("R4 random post", mem.exists(iph) ? mem[iph] : ~d, d);
            iph = step(iph, SIP);
          end
        end
        1: begin
          host_fetch(r);
          if (oph == opt) chk("R8 random empty read", r, 32'hFFFF_FFFF);
          else begin
            chk("R7 random fetch", r, mem[opt]);
            opt = step(opt, SOP);
          end
        end
        2: if (step(oph, SOP) != opt) begin
          d = $urandom;
          mem[oph] = d;
          oph = step(oph, SOP);
          cpu_write(8, oph);
        end
        default: if (ipt != iph) begin
          ipt = step(ipt, SIP);
          cpu_write(7, ipt);
        end
      endcase
      @(negedge clk);
      chk("R10 random empty flags", {28'd0, q_empty}, exp_empty());
    end
    cpu_read(6, r); chk("R4 final inbound head", r, iph);
    cpu_read(9, r); chk("R7 final outbound tail", r, opt);
    chk("R13 request stable until ack", hold_bad, 0);
    report();
  end
endmodule